// File: doc/BRIEF.md
# SPI Master Controller with Status Flags

This block is an 8-bit SPI master driven by a byte-wide host register port. The host sets the clock polarity, clock phase and SCK rate in a control register, then writes a byte to the data register to start a transfer. The byte goes out on MOSI most significant bit first while eight bits are captured from MISO. When the transfer ends, a completion flag and a status register report the result, and a combined interrupt line summarises the flags.

The flags are sticky and clear only through set access orders. Completion and write collision clear when the host reads the status register and then reads or writes the data register. Overrun clears on a status read alone. A mode fault clears when the host reads the status register and then writes the control register. On an overrun the byte already held for the host is kept, and the newly received byte is dropped. A low level on the slave-select input means another master is driving the bus. It latches a mode fault, aborts any transfer and parks SCK at its idle level.

The two host registers are selected by `reg_sel`. When `reg_sel` is 0 the status register is read and the control register is written. When `reg_sel` is 1 the data register is accessed: a read returns the receive byte and a write supplies a byte to send. Status read layout: bit 7 complete, bit 6 write collision, bit 5 overrun, bit 4 transmit empty, bit 3 mode fault, bits 2:0 rate code. Control write layout: bit 7 fault interrupt enable, bit 6 transmit-empty interrupt enable, bit 5 CPHA, bit 4 CPOL, bit 3 unused, bits 2:0 rate code.

Top module: `spim_top`

## Requirements
- R1: After reset the status register reads 0x14 (transmit empty set, rate code 100, all other flags clear), SCK is low and `irq` is low.
- R2: A data write while transmit-empty is set and the rate code is valid starts an 8-bit transfer. Transmit-empty is clear for exactly 16·2^c clock cycles, where c is the rate code: 000=/2, 001=/4, 010=/8, 011=/16, 100=/32, 101=/64, 110=/128 of the clock.
- R3: With CPOL=0, SCK idles low. With CPOL=1, SCK idles high.
- R4: Bits are shifted MSB first. With CPHA=0 MISO is sampled on the edge leaving idle, and with CPHA=1 on the edge returning to idle. In all four modes the byte written goes out and the byte captured is read back from the data register.
- R5: The complete flag (status bit 7) sets at the end of a transfer. It clears only after a status read is followed by a data read or write; a data access with no status read before it leaves the flag set.
- R6: If a transfer ends while the complete flag is still set, overrun (bit 5) is set and the receive register keeps its earlier byte. The next status read clears overrun.
- R7: A data write during a transfer has no effect on the byte being sent and sets write collision (bit 6). Write collision clears through the same sequence as the complete flag.
- R8: With rate code 111 a data write starts nothing: SCK stays idle and transmit-empty stays set.
- R9: A low level on `ss_n_in` latches mode fault (bit 3) within three clock cycles. It aborts a running transfer with SCK returned to idle, transmit-empty set and the complete flag left clear, and it blocks new transfers. Mode fault clears only after a status read is followed by a control write, with `ss_n_in` high.
- R10: `irq` is high exactly when complete is set, or mode fault is set with bit 7 of the control register set, or transmit-empty is set with bit 6 of the control register set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects status/control, 1 selects data |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe; read side effects occur on it |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n_in | input | 1 | Slave-select sense; low signals a competing master |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is a mode fault that lands in the middle of a shift. It has to abort cleanly, hold off later data writes and then survive a control write made before the status read. The bench starts a slow transfer at /16 with SCK idling high, pulls `ss_n_in` low partway through, and then tries to send while the fault is latched. It writes the control register once without arming the clear and once after a status read, and it watches SCK and the flags at each step. An overrun needs two transfers back to back with no flag clearing between them. The bench runs them with a bench-side slave model, so that the retained byte can be told apart from the dropped one.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int SPIM_DATA_W = 8;
  localparam int SPIM_RATE_W = 3;
  // widest half period is 2^(2^RATE_W - 2) clocks
  localparam int SPIM_HALF_W = (1 << SPIM_RATE_W) - 1;
  localparam int SPIM_EDGES  = 2 * SPIM_DATA_W;
  localparam int SPIM_EDGE_W = $clog2(SPIM_EDGES);

  typedef logic [SPIM_RATE_W-1:0] rate_t;

  typedef struct packed {
    logic  done;
    logic  wcol;
    logic  ovr;
    logic  txe;
    logic  modf;
    rate_t rate;
  } status_t;

  // clocks per SCK half period for a rate code
  function automatic logic [SPIM_HALF_W-1:0] half_len(rate_t code);
    return SPIM_HALF_W'(1) << code;
  endfunction

  // all-ones rate code is reserved
  function automatic logic rate_ok(rate_t code);
    return code != '1;
  endfunction
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
  import spim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_t rate,
  output logic  tick
);
  logic [SPIM_HALF_W-1:0] cnt;

  assign tick = run && (cnt == half_len(rate) - SPIM_HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + SPIM_HALF_W'(1);
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   abort,
  input  logic                   tick,
  input  logic                   cpol,
  input  logic                   cpha,
  input  logic [SPIM_DATA_W-1:0] tx_byte,
  input  logic                   miso,
  output logic                   busy,
  output logic                   sck,
  output logic                   mosi,
  output logic                   done_evt,
  output logic [SPIM_DATA_W-1:0] rx_byte
);
  localparam logic [SPIM_EDGE_W-1:0] LAST = SPIM_EDGE_W'(SPIM_EDGES - 1);

  logic [SPIM_EDGE_W-1:0] edge_idx;
  logic [SPIM_DATA_W-1:0] sr;
  logic                   samp;
  logic                   sample_edge, shift_edge;

  // even edges leave idle; CPHA picks which parity samples
  assign sample_edge = busy && tick && (edge_idx[0] == cpha);
  assign shift_edge  = busy && tick && (edge_idx[0] != cpha) &&
                       !(cpha && edge_idx == '0);
  assign done_evt    = busy && tick && (edge_idx == LAST) && !abort;
  assign rx_byte     = {sr[SPIM_DATA_W-2:0], cpha ? miso : samp};
  assign sck         = busy ? (cpol ^ edge_idx[0]) : cpol;
  assign mosi        = sr[SPIM_DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      edge_idx <= '0;
      sr       <= '0;
      samp     <= 1'b0;
    end else if (abort) begin
      busy     <= 1'b0;
      edge_idx <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      edge_idx <= '0;
      sr       <= tx_byte;
    end else if (busy && tick) begin
      edge_idx <= edge_idx + SPIM_EDGE_W'(1);
      if (sample_edge) samp <= miso;
      if (shift_edge)  sr   <= {sr[SPIM_DATA_W-2:0], samp};
      if (edge_idx == LAST) busy <= 1'b0;
    end
  end

  p_abort_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);
  p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_sel,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [SPIM_DATA_W-1:0] reg_wdata,
  input  logic                   busy,
  input  logic                   done_evt,
  input  logic [SPIM_DATA_W-1:0] rx_new,
  input  logic                   fault,
  output logic [SPIM_DATA_W-1:0] reg_rdata,
  output logic                   start,
  output logic                   abort,
  output logic                   cpol,
  output logic                   cpha,
  output rate_t                  rate,
  output logic                   irq
);
  logic mf_ie, tx_ie;
  logic done, wcol, ovr, modf, seen_done, seen_mf;
  logic [SPIM_DATA_W-1:0] rx_q;
  logic stat_rd, ctrl_wr, data_acc, data_wr, collide, clr_done;
  logic unused_spare;
  status_t st;

  assign stat_rd  = reg_rd && !reg_sel;
  assign ctrl_wr  = reg_wr && !reg_sel;
  assign data_wr  = reg_wr && reg_sel;
  assign data_acc = (reg_rd || reg_wr) && reg_sel;
  assign collide  = data_wr && busy;
  assign clr_done = data_acc && seen_done;
  assign start    = data_wr && !busy && rate_ok(rate) && !modf && !fault;
  assign abort    = fault || modf;
  assign unused_spare = reg_wdata[3];

  assign st        = '{done: done, wcol: wcol, ovr: ovr, txe: !busy,
                       modf: modf, rate: rate};
  assign reg_rdata = reg_sel ? rx_q : st;
  assign irq       = done || (modf && mf_ie) || (!busy && tx_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_ie <= 1'b0; tx_ie <= 1'b0; cpha <= 1'b0; cpol <= 1'b0;
      rate  <= rate_t'(4);
    end else if (ctrl_wr) begin
      mf_ie <= reg_wdata[7]; tx_ie <= reg_wdata[6];
      cpha  <= reg_wdata[5]; cpol  <= reg_wdata[4];
      rate  <= reg_wdata[SPIM_RATE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; wcol <= 1'b0; ovr <= 1'b0; modf <= 1'b0;
      seen_done <= 1'b0; seen_mf <= 1'b0; rx_q <= '0;
    end else begin
      if (done_evt)      done <= 1'b1;
      else if (clr_done) done <= 1'b0;

      if (done_evt && !done) rx_q <= rx_new;

      if (done_evt && done) ovr <= 1'b1;
      else if (stat_rd)     ovr <= 1'b0;

      if (collide)       wcol <= 1'b1;
      else if (clr_done) wcol <= 1'b0;

      if (stat_rd)       seen_done <= done;
      else if (data_acc) seen_done <= 1'b0;

      if (fault)                   modf <= 1'b1;
      else if (ctrl_wr && seen_mf) modf <= 1'b0;

      if (stat_rd)      seen_mf <= modf;
      else if (ctrl_wr) seen_mf <= 1'b0;
    end
  end

  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done);
  p_ovr_keeps_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && done) |=> (ovr && $stable(rx_q)));
  p_wcol_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> wcol);
  p_bad_rate_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rate_ok(rate)) |=> !busy);
  p_fault_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> modf);
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_sel,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [SPIM_DATA_W-1:0] reg_wdata,
  output logic [SPIM_DATA_W-1:0] reg_rdata,
  output logic                   sck,
  output logic                   mosi,
  input  logic                   miso,
  input  logic                   ss_n_in,
  output logic                   irq
);
  logic [SYNC_STAGES-1:0] ss_sync;
  logic fault, start, abort, busy, tick, done_evt, cpol, cpha;
  rate_t rate;
  logic [SPIM_DATA_W-1:0] rx_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_sync <= '1;
    else        ss_sync <= {ss_sync[SYNC_STAGES-2:0], ss_n_in};
  end
  assign fault = !ss_sync[SYNC_STAGES-1];

  spim_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .busy(busy),
    .done_evt(done_evt), .rx_new(rx_new), .fault(fault),
    .reg_rdata(reg_rdata), .start(start), .abort(abort), .cpol(cpol),
    .cpha(cpha), .rate(rate), .irq(irq)
  );

  spim_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate), .tick(tick)
  );

  spim_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .tick(tick),
    .cpol(cpol), .cpha(cpha), .tx_byte(reg_wdata), .miso(miso),
    .busy(busy), .sck(sck), .mosi(mosi), .done_evt(done_evt),
    .rx_byte(rx_new)
  );
endmodule

// File: tb/test_spim_top.sv
module test_spim_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sck, mosi, irq;
  logic miso = 1'b0;
  logic ss_n_in = 1'b1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spim_top i_spim_top (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n_in(ss_n_in), .irq(irq)
  );

  // bench slave: shifts out 9-bit staging so both phases share one rule
  logic       slv_on = 1'b0;
  logic       slv_cpol = 1'b0, slv_cpha = 1'b0;
  logic [8:0] slv_out = '0;
  logic [7:0] slv_in = '0;

  always @(sck) begin
    if (slv_on) begin
      if ((sck != slv_cpol) ^ slv_cpha) slv_in = {slv_in[6:0], mosi};
      else begin
        slv_out = slv_out << 1;
        miso = slv_out[8];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic arm_slave(input logic pol, input logic pha, input logic [7:0] s);
    slv_cpol = pol; slv_cpha = pha; slv_in = '0;
    slv_out = pha ? {1'b0, s} : {s, 1'b0};
    miso = slv_out[8];
    slv_on = 1'b1;
  endtask

  // {cpol, cpha, rate, master byte, slave byte}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 3'd1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 3'd2, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 3'd3, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 3'd6, 8'h96, 8'h69},
    {1'b1, 1'b1, 3'd0, 8'h01, 8'h80}
  };

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 sck", sck, 0);
    chk("R1 irq", irq, 0);
    host_rd(0, d); chk("R1 status", d, 8'h14);

    // table walk: modes, rates, data (R2 R3 R4)
    for (int i = 0; i < 6; i++) begin
      logic pol, pha; logic [2:0] rt; logic [7:0] mb, sb;
      {pol, pha, rt, mb, sb} = VEC[i];
      slv_on = 1'b0;
      host_wr(0, {2'b01, pha, pol, 1'b0, rt});
      @(negedge clk);
      chk("R3 idle level", sck, pol);
      arm_slave(pol, pha, sb);
      host_wr(1, mb);
      n = 0;
      while (irq == 1'b0 && n < 5000) begin n++; @(negedge clk); end
      chk("R2 busy length", n, 16 << rt);
      chk("R4 slave got", slv_in, mb);
      chk("R3 idle after", sck, pol);
      host_rd(0, d); chk("R5 status done", d, {5'b10010, rt});
      host_rd(1, d); chk("R4 master got", d, sb);
      slv_on = 1'b0;
    end

    // R5: clear needs status read first
    host_wr(0, 8'h00);
    arm_slave(0, 0, 8'h22); host_wr(1, 8'h11); repeat (24) @(negedge clk);
    chk("R10 irq from done", irq, 1);
    host_rd(1, d); chk("R5 data", d, 8'h22);
    chk("R5 done kept", irq, 1);
    host_rd(0, d); chk("R5 status", d, 8'h90);
    host_rd(1, d);
    chk("R5 done cleared", irq, 0);

    // R6 overrun keeps first byte
    arm_slave(0, 0, 8'h5A); host_wr(1, 8'h33); repeat (24) @(negedge clk);
    arm_slave(0, 0, 8'hC3); host_wr(1, 8'h44); repeat (24) @(negedge clk);
    host_rd(0, d); chk("R6 ovr status", d, 8'hB0);
    host_rd(1, d); chk("R6 kept byte", d, 8'h5A);
    host_rd(0, d); chk("R6 ovr cleared", d, 8'h10);

    // R7 write collision
    arm_slave(0, 0, 8'h00);
    host_wr(1, 8'hA7); host_wr(1, 8'h3B); repeat (24) @(negedge clk);
    chk("R7 sent byte", slv_in, 8'hA7);
    host_rd(0, d); chk("R7 wcol set", d, 8'hD0);
    host_rd(1, d);
    host_rd(0, d); chk("R7 wcol cleared", d, 8'h10);

    // R8 reserved rate
    slv_on = 1'b0;
    host_wr(0, 8'h07);
    host_wr(1, 8'h55);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      if (sck !== 1'b0) n++;
      @(negedge clk);
    end
    chk("R8 sck idle", n, 0);
    host_rd(0, d); chk("R8 txe kept", d, 8'h17);

    // R9 mode fault mid transfer, cpol=1, /16
    host_wr(0, 8'h13);
    arm_slave(1, 0, 8'hFF); host_wr(1, 8'hFF);
    repeat (20) @(negedge clk);
    slv_on = 1'b0;
    ss_n_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 sck idle", sck, 1);
    host_wr(0, 8'h93);
    chk("R10 irq fault", irq, 1);
    host_wr(1, 8'h12);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      if (sck !== 1'b1) n++;
      @(negedge clk);
    end
    chk("R9 blocked", n, 0);
    ss_n_in = 1'b1;
    repeat (3) @(negedge clk);
    host_wr(0, 8'h93);
    host_rd(0, d); chk("R9 fault held", d, 8'h1B);
    host_wr(0, 8'h13);
    chk("R10 irq low", irq, 0);
    host_rd(0, d); chk("R9 fault cleared", d, 8'h13);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule